// File: doc/BRIEF.md
# A/D Conversion Control Sequencer

This block is the digital half of a successive-approximation analog-to-digital converter inside a small microcontroller. Software writes a clock-select register and a control register. The control register names the sampled channel, sets how many port pins act as analog inputs, and carries a start bit. Setting the start bit resets the converter. Clearing it again launches one conversion. A divider turns the system clock into a conversion clock. On each tick of that clock the sequencer settles one bit of a trial code against a digital comparator input, starting with the most significant bit.

The finished 12-bit code is placed in two byte-wide result registers. A done flag is then set, and it raises an interrupt only when both the converter enable and the global enable are high. The flag stays set until software writes the flag address. A further conversion needs a fresh low-high-low pulse on the start bit. After a change to the channel or pin fields, that pulse must end within a fixed number of cycles. If it does not, a sticky error bit is set.

The analog comparator, the trial DAC and the input multiplexer are modelled only as digital signals: `dac_code` goes out and `cmp_in` comes back.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, `busy`, `adf`, `irq`, `seq_err`, `res_hi`, `res_lo`, `dac_code`, `chan_sel` and `pin_mask` are all zero, and the clock select is code 0.
- R2: A write to address 1 stores bits [6:4] as a pin-count code c and bits [3:0] as `chan_sel`. `pin_mask` then has its lowest min(2c, 8) bits set and the rest clear.
- R3: `res_hi` holds result bits [11:4]. `res_lo` holds result bits [3:0] in its upper nibble, with its lower nibble zero.
- R4: The conversion tests one bit per tick from bit 11 down to bit 0. A bit is kept when `cmp_in` is 1 while `dac_code` shows the trial, so the result equals the input level the comparator sees.
- R5: Clock-select (address 0, bits [1:0]) codes 0, 1 and 2 give a tick every 2, 8 and 32 cycles. `busy` stays high for exactly 12 tick periods from the cycle after the start bit falls. At its end the result is stored and `adf` is set.
- R6: `irq` is 1 exactly when `adf`, `ie_adc` and `ie_glb` are all 1.
- R7: `adf` is set only at the end of a conversion. It stays set until any write to address 2 clears it. No new conversion begins without another start pulse.
- R8: Clock-select code 3 stops the divider. A conversion started under it stays busy with `dac_code` frozen at its first trial of 0x800, and `adf` stays clear.
- R9: Raising the start bit (bit 7 of address 1) clears `busy` and `adf` on the next cycle, which aborts any conversion in progress. Clearing it starts a fresh conversion.
- R10: Writing a changed channel or pin-count field begins a window. If the start bit does not fall within 10 cycles of that write, `seq_err` is set, and it stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 clock select, 1 control, 2 flag clear |
| wr_data | input | 8 | Write data |
| cmp_in | input | 1 | Comparator: 1 when the input level is at or above `dac_code` |
| ie_adc | input | 1 | Converter interrupt enable |
| ie_glb | input | 1 | Global interrupt enable |
| chan_sel | output | 4 | Selected analog channel |
| pin_mask | output | 8 | Port pins switched to analog input |
| dac_code | output | 12 | Trial code driven to the DAC |
| busy | output | 1 | Conversion in progress |
| adf | output | 1 | End-of-conversion flag |
| irq | output | 1 | Interrupt request |
| seq_err | output | 1 | Sticky late-start error |
| res_hi | output | 8 | Result bits 11:4 |
| res_lo | output | 8 | Result bits 3:0 in the upper nibble |

## Verification
The properties check, on every cycle, these invariants:
- the interrupt gating;
- that `adf` never stands during a busy period;
- that a conversion ending without an abort always sets `adf`;
- that the trial code moves only on a divider tick;
- that the pin mask is contiguous;
- that the error bit never clears.

Only the bench's scenarios can show the following:
- the exact result values for distinct input levels;
- the busy length under each divider code;
- the frozen hold-code conversion;
- the abort-and-restart sequence;
- the late pulse after a field change.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        CK_DIV2  = 2'd0,
        CK_DIV8  = 2'd1,
        CK_DIV32 = 2'd2,
        CK_HOLD  = 2'd3
    } ck_sel_e;

    localparam logic [1:0] A_CKSEL = 2'd0;
    localparam logic [1:0] A_CTRL  = 2'd1;
    localparam logic [1:0] A_FLAG  = 2'd2;

    localparam int DIVW = 5;

    // terminal count of the divider for each select code
    function automatic logic [DIVW-1:0] div_limit(input ck_sel_e s);
        case (s)
            CK_DIV2:  div_limit = 5'd1;
            CK_DIV8:  div_limit = 5'd7;
            CK_DIV32: div_limit = 5'd31;
            default:  div_limit = 5'd31;
        endcase
    endfunction

endpackage

// File: rtl/adc_clkdiv.sv
module adc_clkdiv
    import adc_seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    restart,
    input  logic    run,
    input  ck_sel_e sel,
    output logic    tick
);

    typedef struct packed {
        logic [DIVW-1:0] cnt;
    } div_st_t;

    div_st_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        tick = 1'b0;
        if (restart || !run) begin
            s_d.cnt = '0;
        end else if (sel != CK_HOLD) begin
            if (s_q.cnt == div_limit(sel)) begin
                tick    = 1'b1;
                s_d.cnt = '0;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic         abort,
    input  logic         tick,
    input  logic         cmp_in,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] trial,
    output logic [W-1:0] result
);

    localparam int IW = $clog2(W);

    typedef struct packed {
        logic          busy;
        logic [IW-1:0] idx;
        logic [W-1:0]  trial;
        logic [W-1:0]  result;
    } sar_st_t;

    sar_st_t      s_d, s_q;
    logic [W-1:0] kept;

    always_comb begin
        s_d          = s_q;
        done         = 1'b0;
        kept         = s_q.trial;
        kept[s_q.idx] = cmp_in;
        if (abort) begin
            s_d.busy  = 1'b0;
            s_d.trial = '0;
        end else if (go) begin
            s_d.busy  = 1'b1;
            s_d.idx   = IW'(W - 1);
            s_d.trial = {1'b1, {(W-1){1'b0}}};
        end else if (s_q.busy && tick) begin
            if (s_q.idx == '0) begin
                s_d.busy   = 1'b0;
                s_d.trial  = kept;
                s_d.result = kept;
                done       = 1'b1;
            end else begin
                s_d.idx   = s_q.idx - 1'b1;
                s_d.trial = kept | (W'(1) << (s_q.idx - 1'b1));
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy   = s_q.busy;
    assign trial  = s_q.trial;
    assign result = s_q.result;

endmodule

// File: rtl/adc_cfg_regs.sv
module adc_cfg_regs
    import adc_seq_pkg::*;
#(
    parameter int NPINS    = 8,
    parameter int DEADLINE = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [7:0]       wr_data,
    input  logic             conv_done,
    output ck_sel_e          cksel,
    output logic [3:0]       chan,
    output logic [NPINS-1:0] pin_mask,
    output logic             start_rise,
    output logic             start_fall,
    output logic             adf,
    output logic             seq_err
);

    localparam int DLW = $clog2(DEADLINE + 1);

    typedef struct packed {
        ck_sel_e        cksel;
        logic           start;
        logic [2:0]     pcfg;
        logic [3:0]     chan;
        logic           adf;
        logic           err;
        logic           armed;
        logic [DLW-1:0] dl;
    } cfg_st_t;

    cfg_st_t s_d, s_q;
    logic    cfg_chg;

    always_comb begin
        s_d        = s_q;
        start_rise = 1'b0;
        start_fall = 1'b0;
        cfg_chg    = 1'b0;
        if (wr_en && wr_addr == A_CKSEL)
            s_d.cksel = ck_sel_e'(wr_data[1:0]);
        if (wr_en && wr_addr == A_CTRL) begin
            s_d.start  = wr_data[7];
            s_d.pcfg   = wr_data[6:4];
            s_d.chan   = wr_data[3:0];
            start_rise = wr_data[7] && !s_q.start;
            start_fall = !wr_data[7] && s_q.start;
            cfg_chg    = (wr_data[6:4] != s_q.pcfg) || (wr_data[3:0] != s_q.chan);
        end
        // start-pulse deadline after a field change
        if (cfg_chg) begin
            s_d.armed = 1'b1;
            s_d.dl    = DLW'(1);
        end else if (s_q.armed) begin
            if (start_fall) begin
                s_d.armed = 1'b0;
            end else if (s_q.dl == DLW'(DEADLINE)) begin
                s_d.armed = 1'b0;
                s_d.err   = 1'b1;
            end else begin
                s_d.dl = s_q.dl + 1'b1;
            end
        end
        // end-of-conversion flag
        if (start_rise)                       s_d.adf = 1'b0;
        else if (conv_done)                   s_d.adf = 1'b1;
        else if (wr_en && wr_addr == A_FLAG)  s_d.adf = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    for (genvar i = 0; i < NPINS; i++) begin : g_mask
        assign pin_mask[i] = (i < 2 * int'(s_q.pcfg));
    end

    assign cksel   = s_q.cksel;
    assign chan    = s_q.chan;
    assign adf     = s_q.adf;
    assign seq_err = s_q.err;

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int W        = 12,
    parameter int NPINS    = 8,
    parameter int DEADLINE = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [7:0]       wr_data,
    input  logic             cmp_in,
    input  logic             ie_adc,
    input  logic             ie_glb,
    output logic [3:0]       chan_sel,
    output logic [NPINS-1:0] pin_mask,
    output logic [W-1:0]     dac_code,
    output logic             busy,
    output logic             adf,
    output logic             irq,
    output logic             seq_err,
    output logic [7:0]       res_hi,
    output logic [7:0]       res_lo
);

    // result width must lie between 9 and 16 bits
    localparam int LO = W - 8;

    ck_sel_e      cksel;
    logic         start_rise;
    logic         start_fall;
    logic         div_tick;
    logic         conv_done;
    logic [W-1:0] result;

    adc_cfg_regs #(.NPINS(NPINS), .DEADLINE(DEADLINE)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .conv_done  (conv_done),
        .cksel      (cksel),
        .chan       (chan_sel),
        .pin_mask   (pin_mask),
        .start_rise (start_rise),
        .start_fall (start_fall),
        .adf        (adf),
        .seq_err    (seq_err)
    );

    adc_clkdiv u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (start_fall),
        .run     (busy),
        .sel     (cksel),
        .tick    (div_tick)
    );

    adc_sar_core #(.W(W)) u_sar (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (start_fall),
        .abort  (start_rise),
        .tick   (div_tick),
        .cmp_in (cmp_in),
        .busy   (busy),
        .done   (conv_done),
        .trial  (dac_code),
        .result (result)
    );

    assign irq    = adf & ie_adc & ie_glb;
    assign res_hi = result[W-1:W-8];
    assign res_lo = 8'(result[LO-1:0]) << (8 - LO);

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
    parameter int W     = 12,
    parameter int NPINS = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             adf,
    input logic             irq,
    input logic             ie_adc,
    input logic             ie_glb,
    input logic             seq_err,
    input logic [NPINS-1:0] pin_mask,
    input logic [W-1:0]     dac_code,
    input logic             start_rise,
    input logic             start_fall,
    input logic             div_tick
);

    AST_IRQ_NEEDS_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (adf && ie_adc && ie_glb)); // R6

    AST_NO_ADF_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !adf); // R9

    AST_END_RAISES_ADF: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !$past(start_rise)) |-> adf); // R5

    AST_ADF_ONLY_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adf) |-> $past(busy)); // R7

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(seq_err) |-> seq_err); // R10

    AST_DAC_HOLDS_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$past(div_tick) && !$past(start_fall) && !$past(start_rise))
        |-> $stable(dac_code)); // R8

    AST_START_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start_rise |=> (!busy && !adf)); // R9

    AST_MASK_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_mask + NPINS'(1)) & pin_mask) == '0); // R2

endmodule

bind adc_seq_ctrl adc_seq_chk #(.W(W), .NPINS(NPINS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .adf        (adf),
    .irq        (irq),
    .ie_adc     (ie_adc),
    .ie_glb     (ie_glb),
    .seq_err    (seq_err),
    .pin_mask   (pin_mask),
    .dac_code   (dac_code),
    .start_rise (start_rise),
    .start_fall (start_fall),
    .div_tick   (div_tick)
);

// File: tb/tb_adc_seq_ctrl.sv
module tb_adc_seq_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 12;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [1:0]  wr_addr;
    logic [7:0]  wr_data;
    logic        cmp_in;
    logic        ie_adc;
    logic        ie_glb;
    logic [3:0]  chan_sel;
    logic [7:0]  pin_mask;
    logic [W-1:0] dac_code;
    logic        busy;
    logic        adf;
    logic        irq;
    logic        seq_err;
    logic [7:0]  res_hi;
    logic [7:0]  res_lo;
    logic [W-1:0] vin;

    adc_seq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cmp_in(cmp_in), .ie_adc(ie_adc), .ie_glb(ie_glb), .chan_sel(chan_sel),
        .pin_mask(pin_mask), .dac_code(dac_code), .busy(busy), .adf(adf), .irq(irq),
        .seq_err(seq_err), .res_hi(res_hi), .res_lo(res_lo)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // comparator model: input level at or above the trial code
    assign cmp_in = (vin >= dac_code);

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    typedef struct {
        logic [W-1:0] v;
        int           div;
    } exp_t;
    exp_t sbq[$];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int div_of(input logic [1:0] sel);
        case (sel)
            2'd0:    return 2;
            2'd1:    return 8;
            default: return 32;
        endcase
    endfunction

    // called at a negedge; returns at the next negedge
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_adf();
        while (!adf) @(negedge clk);
    endtask

    task automatic convert(input logic [W-1:0] v, input logic [1:0] sel, input logic [7:0] cfg);
        exp_t e;
        vin = v;
        wr(2'd0, {6'd0, sel});
        e.v = v; e.div = div_of(sel);
        sbq.push_back(e);
        wr(2'd1, cfg | 8'h80);
        wr(2'd1, cfg);
        wait_adf();
        check("R5 busy low at end", 32'(busy), 0);
        wr(2'd2, 8'h00);
        check("R7 adf cleared by flag write", 32'(adf), 0);
    endtask

    // monitor: busy length and result against the scoreboard
    int  bcnt = 0;
    bit  busy_prev = 1'b0;
    bit  adf_prev  = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy && !busy_prev) bcnt = 1;
            else if (busy)          bcnt++;
            if (adf && !adf_prev) begin
                if (sbq.size() == 0) begin
                    check("R7 adf without expected conversion", 32'(adf), 0);
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    check("R4 res_hi value", 32'(res_hi), 32'(e.v[11:4]));
                    check("R3 res_lo nibble", 32'(res_lo), 32'({e.v[3:0], 4'h0}));
                    check("R5 busy length", 32'(bcnt), 32'(12 * e.div));
                end
            end
            busy_prev = busy;
            adf_prev  = adf;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        ie_adc = 1'b0; ie_glb = 1'b0; vin = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 busy", 32'(busy), 0);
        check("R1 adf", 32'(adf), 0);
        check("R1 irq", 32'(irq), 0);
        check("R1 seq_err", 32'(seq_err), 0);
        check("R1 res_hi", 32'(res_hi), 0);
        check("R1 res_lo", 32'(res_lo), 0);
        check("R1 dac_code", 32'(dac_code), 0);
        check("R1 pin_mask", 32'(pin_mask), 0);
        check("R1 chan_sel", 32'(chan_sel), 0);

        // R2 configuration with an in-time start pulse (R10 no error)
        begin
            exp_t e;
            vin = 12'h5A3;
            wr(2'd1, 8'h20);
            check("R2 pin_mask for code 2", 32'(pin_mask), 32'h0F);
            check("R2 chan_sel 0", 32'(chan_sel), 0);
            e.v = 12'h5A3; e.div = 2;
            sbq.push_back(e);
            wr(2'd1, 8'hA0);
            wr(2'd1, 8'h20);
            wait_adf();
        end
        check("R10 no error on in-time pulse", 32'(seq_err), 0);

        // R6 interrupt gating over all enable pairs while adf is set
        for (int k = 0; k < 4; k++) begin
            ie_adc = k[0]; ie_glb = k[1];
            #1;
            check("R6 irq gating", 32'(irq), 32'(k == 3));
        end
        ie_adc = 1'b0; ie_glb = 1'b0;
        @(negedge clk);
        wr(2'd2, 8'h00);
        check("R7 adf cleared", 32'(adf), 0);

        // R4/R5 conversions under several levels and dividers
        ie_adc = 1'b1; ie_glb = 1'b1;
        convert(12'hFFF, 2'd1, 8'h20);
        convert(12'h000, 2'd0, 8'h20);
        convert(12'hA5C, 2'd2, 8'h20);
        convert(12'h123, 2'd1, 8'h20);
        convert(12'h800, 2'd0, 8'h20);
        convert(12'h7FF, 2'd0, 8'h20);
        check("R6 irq low after clear", 32'(irq), 0);

        // R7 no new conversion without a pulse
        repeat (50) @(negedge clk);
        check("R7 stays idle busy", 32'(busy), 0);
        check("R7 stays idle adf", 32'(adf), 0);

        // R8 hold code freezes the conversion
        vin = 12'h3C6;
        wr(2'd0, 8'h03);
        wr(2'd1, 8'hA0);
        wr(2'd1, 8'h20);
        repeat (100) @(negedge clk);
        check("R8 still busy under hold", 32'(busy), 1);
        check("R8 adf clear under hold", 32'(adf), 0);
        check("R8 dac frozen at first trial", 32'(dac_code), 32'h800);

        // R9 abort via start rise, then restart
        wr(2'd1, 8'hA0);
        check("R9 abort clears busy", 32'(busy), 0);
        check("R9 abort leaves adf clear", 32'(adf), 0);
        wr(2'd0, 8'h01);
        begin
            exp_t e;
            e.v = 12'h3C6; e.div = 8;
            sbq.push_back(e);
        end
        wr(2'd1, 8'h20);
        wait_adf();
        wr(2'd2, 8'h00);

        // R9 abort in mid conversion
        vin = 12'h9E1;
        wr(2'd1, 8'hA0);
        wr(2'd1, 8'h20);
        repeat (30) @(negedge clk);
        check("R9 busy mid conversion", 32'(busy), 1);
        wr(2'd1, 8'hA0);
        check("R9 mid abort clears busy", 32'(busy), 0);
        repeat (5) @(negedge clk);
        check("R9 adf stays clear after abort", 32'(adf), 0);
        vin = 12'h2B4;
        begin
            exp_t e;
            e.v = 12'h2B4; e.div = 8;
            sbq.push_back(e);
        end
        wr(2'd1, 8'h20);
        wait_adf();
        wr(2'd2, 8'h00);
        check("R10 still no error", 32'(seq_err), 0);

        // R10 late pulse after a field change
        wr(2'd1, 8'h35);
        check("R2 pin_mask for code 3", 32'(pin_mask), 32'h3F);
        check("R2 chan_sel 5", 32'(chan_sel), 5);
        repeat (12) @(negedge clk);
        check("R10 late pulse sets error", 32'(seq_err), 1);
        vin = 12'h6D9;
        begin
            exp_t e;
            e.v = 12'h6D9; e.div = 8;
            sbq.push_back(e);
        end
        wr(2'd1, 8'hB5);
        wr(2'd1, 8'h35);
        wait_adf();
        wr(2'd2, 8'h00);
        check("R10 error sticky", 32'(seq_err), 1);

        wr(2'd1, 8'h70);
        check("R2 pin_mask capped at 8 pins", 32'(pin_mask), 32'hFF);
        repeat (20) @(negedge clk);
        check("R10 error still sticky", 32'(seq_err), 1);
        check("R4 scoreboard drained", 32'(sbq.size()), 0);

        done_flag = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule